// File: doc/BRIEF.md
# Interrupt Redirection MSI Generator

This block takes a set of interrupt input lines and turns each assertion into a message-signalled interrupt. A message-signalled interrupt is a 32-bit address plus a 32-bit data word that a bus master would post as a memory write. Each line owns a 64-bit redirection entry. Software programs the entry through two registers: an index register that picks a word, and a 32-bit data window that reads or writes the picked word. The entry holds the vector, the delivery mode, the destination and its addressing mode, the polarity, the trigger type and a mask bit.

Edge-triggered lines raise one message for each inactive-to-active change. Level-triggered lines use a remote-IRR handshake. After a message is accepted, no further message is sent for that line until an end-of-interrupt arrives with the same vector. When several lines are waiting, the lowest-numbered unmasked line goes first. Messages leave on a valid/ready port and stay stable while the port is stalled.

Top module: `irq_redir_msi`

## Requirements
- R1: After reset every entry has its mask bit (low word bit 16) at 1 and all other entry bits at 0. The ID register reads 0 and msgValid is 0.
- R2: Index 0x00 is the ID register: only bits [27:24] can be written, and all other bits read 0. Index 0x01 is read-only and reads bits [7:0]=0x20, bits [23:16]=NUM_PINS-1, and all other bits 0. Index 0x10+2n is the low word of entry n. Index 0x11+2n is its high word, where only bits [31:24] (the destination ID) are stored. Any other index reads 0.
- R3: The low-word fields are: [7:0] vector, [10:8] delivery mode, 11 destination mode, 12 delivery status (read-only), 13 polarity (1 = active low), 14 remote IRR (read-only), 15 trigger (1 = level), 16 mask. Bits [31:17] read 0 and ignore writes.
- R4: The message address is {0xFEE, destination ID, 8'h00, hint, destination mode, 2'b00}. The hint bit (address bit 3) is 1 exactly when the delivery mode is 001.
- R5: The message data is {16'h0, trigger, 1'b1, 3'b000, delivery mode, vector}. Bit 14 (the assert bit) is always 1.
- R6: An unmasked edge line sends exactly one message per inactive-to-active change, with polarity applied. Holding the line active or returning it to inactive sends nothing.
- R7: A masked line sends no message. An edge that occurs while the line is masked is lost. A level line that is still active when it is unmasked then sends a message.
- R8: Delivery status reads 1 from the moment an edge is detected until the handshake for its message completes, including while msgReady is held low. It reads 0 afterwards.
- R9: While msgValid is high and msgReady is low, msgValid stays high and msgAddr and msgData do not change.
- R10: On the handshake of a level-line message, remote IRR is set to 1 and the line sends nothing more while it stays active. An end-of-interrupt whose vector differs from the entry's vector leaves remote IRR at 1.
- R11: An end-of-interrupt whose vector matches clears remote IRR. If the line is still active, it then sends a new message.
- R12: Lines that are waiting at the same time are delivered in ascending line order, with one message per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWrEn | input | 1 | Write strobe for the index register |
| selWrData | input | 8 | New index value |
| winWrEn | input | 1 | Write strobe for the data window |
| winWrData | input | 32 | Data written to the selected word |
| winRdData | output | 32 | Contents of the selected word |
| irqIn | input | NUM_PINS | Raw interrupt input lines |
| eoiValid | input | 1 | End-of-interrupt strobe |
| eoiVector | input | 8 | Vector carried by the end-of-interrupt |
| msgValid | output | 1 | Message is available |
| msgReady | input | 1 | Receiver accepts the message |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
The bench builds the block with NUM_PINS=6, which puts the whole table at indices 0x10 to 0x1B. This makes it cheap to sweep every line through both polarities and several delivery modes and destination modes, and to read back every word with all-ones writes. The small line count also lets a single test raise all lines together and check the full ascending delivery order. A stalled handshake, the remote-IRR cycle with mismatched and matched end-of-interrupts, and mask-versus-edge cases are each exercised on a specific line.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned SEL_W = 8;
  localparam logic [7:0] VERSION_CODE = 8'h20;
  localparam logic [7:0] IDX_UNIT_ID = 8'h00;
  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam int unsigned IDX_TABLE_BASE = 16;
  localparam logic [2:0] DM_LOWEST_PRIO = 3'b001;
  localparam logic [11:0] MSG_ADDR_TOP = 12'hFEE;

  // Stored, writable part of one redirection entry
  typedef struct packed {
    logic [7:0] destId;
    logic       mask;
    logic       trigLevel;
    logic       polLow;
    logic       destLogical;
    logic [2:0] delMode;
    logic [7:0] vector;
  } redirEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadMsg;   // latch message from entry pinIdx
    logic       busy;      // a message is being offered
    logic       msgDone;   // handshake completes this cycle
    logic [7:0] pinIdx;    // line concerned by the strobes
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selWrEn,
  input  logic [SEL_W-1:0]    selWrData,
  input  logic                winWrEn,
  input  logic [31:0]         winWrData,
  output logic [31:0]         winRdData,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  input  ctrlStrobes_t        strobes,
  output logic [NUM_PINS-1:0] reqVec,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);

  localparam logic [7:0] MAX_ENTRY = 8'(NUM_PINS - 1);

  logic [SEL_W-1:0]    selQ;
  logic [3:0]          unitIdQ;
  redirEntry_t         tbl [NUM_PINS];
  logic [NUM_PINS-1:0] lineLvlQ;
  logic [NUM_PINS-1:0] pendQ;
  logic [NUM_PINS-1:0] rIrrQ;
  logic [31:0]         msgAddrQ;
  logic [31:0]         msgDataQ;

  redirEntry_t selEntry;
  logic        selPend;
  logic        selRirr;

  function automatic logic [7:0] loIdx(input int unsigned n);
    return 8'(IDX_TABLE_BASE + 2 * n);
  endfunction

  function automatic logic [7:0] hiIdx(input int unsigned n);
    return 8'(IDX_TABLE_BASE + 2 * n + 1);
  endfunction

  // Index register and unit ID
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= '0;
      unitIdQ <= '0;
    end else begin
      if (selWrEn) selQ <= selWrData;
      if (winWrEn && selQ == IDX_UNIT_ID) unitIdQ <= winWrData[27:24];
    end
  end

  // Raw line level bitmap
  always_ff @(posedge clk) begin
    if (!rstN) lineLvlQ <= '0;
    else       lineLvlQ <= irqIn;
  end

  // Per-line entry, pending and remote IRR
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_line
    logic activeNow;
    logic activePrev;
    logic riseEdge;
    logic isSel;
    logic hold;
    logic doneHere;

    assign activeNow  = irqIn[n] ^ tbl[n].polLow;
    assign activePrev = lineLvlQ[n] ^ tbl[n].polLow;
    assign riseEdge   = activeNow && !activePrev;
    assign isSel      = (strobes.pinIdx == 8'(n));
    assign hold       = (strobes.loadMsg || strobes.busy) && isSel;
    assign doneHere   = strobes.msgDone && isSel;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tbl[n]      <= '0;
        tbl[n].mask <= 1'b1;
      end else if (winWrEn && selQ == loIdx(n)) begin
        tbl[n].vector      <= winWrData[7:0];
        tbl[n].delMode     <= winWrData[10:8];
        tbl[n].destLogical <= winWrData[11];
        tbl[n].polLow      <= winWrData[13];
        tbl[n].trigLevel   <= winWrData[15];
        tbl[n].mask        <= winWrData[16];
      end else if (winWrEn && selQ == hiIdx(n)) begin
        tbl[n].destId <= winWrData[31:24];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendQ[n] <= 1'b0;
      end else if (doneHere) begin
        pendQ[n] <= tbl[n].trigLevel ? 1'b0 : (riseEdge && !tbl[n].mask);
      end else if (hold) begin
        pendQ[n] <= 1'b1;
      end else if (tbl[n].trigLevel) begin
        pendQ[n] <= activeNow && !rIrrQ[n] && !tbl[n].mask;
      end else begin
        pendQ[n] <= pendQ[n] || (riseEdge && !tbl[n].mask);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rIrrQ[n] <= 1'b0;
      end else if (doneHere && msgDataQ[15]) begin
        rIrrQ[n] <= 1'b1;
      end else if (eoiValid && rIrrQ[n] && tbl[n].vector == eoiVector) begin
        rIrrQ[n] <= 1'b0;
      end
    end

    assign reqVec[n] = pendQ[n] && !tbl[n].mask;
  end

  // Entry selected by control
  always_comb begin
    selEntry = '0;
    selPend  = 1'b0;
    selRirr  = 1'b0;
    for (int n = 0; n < NUM_PINS; n++) begin
      if (strobes.pinIdx == 8'(n)) begin
        selEntry = tbl[n];
        selPend  = pendQ[n];
        selRirr  = rIrrQ[n];
      end
    end
  end

  // Message latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgAddrQ <= '0;
      msgDataQ <= '0;
    end else if (strobes.loadMsg) begin
      msgAddrQ <= {MSG_ADDR_TOP, selEntry.destId, 8'h00,
                   selEntry.delMode == DM_LOWEST_PRIO,
                   selEntry.destLogical, 2'b00};
      msgDataQ <= {16'h0000, selEntry.trigLevel, 1'b1, 3'b000,
                   selEntry.delMode, selEntry.vector};
    end
  end

  assign msgAddr = msgAddrQ;
  assign msgData = msgDataQ;

  // Window read
  always_comb begin
    winRdData = '0;
    if (selQ == IDX_UNIT_ID) winRdData = {4'h0, unitIdQ, 24'h0};
    if (selQ == IDX_VERSION) winRdData = {8'h00, MAX_ENTRY, 8'h00, VERSION_CODE};
    for (int n = 0; n < NUM_PINS; n++) begin
      if (selQ == loIdx(n)) begin
        winRdData = {15'h0, tbl[n].mask, tbl[n].trigLevel, rIrrQ[n],
                     tbl[n].polLow, pendQ[n], tbl[n].destLogical,
                     tbl[n].delMode, tbl[n].vector};
      end
      if (selQ == hiIdx(n)) winRdData = {tbl[n].destId, 24'h0};
    end
  end

  // A masked line is never picked (R7)
  p_no_masked_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMsg |-> !selEntry.mask);

  // A level line with remote IRR set is never picked (R10)
  p_rirr_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMsg |-> !(selEntry.trigLevel && selRirr));

  // Message contents stay frozen while offered (R9)
  p_msg_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !strobes.msgDone) |=> ($stable(msgAddrQ) && $stable(msgDataQ)));

  // Delivery status is set until the handshake (R8)
  p_pend_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.msgDone |-> selPend);

endmodule

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] reqVec,
  input  logic                msgReady,
  output logic                msgValid,
  output ctrlStrobes_t        strobes
);

  typedef enum logic {ST_IDLE, ST_SEND} ctrlState_t;

  ctrlState_t stateQ;
  logic [7:0] curIdxQ;
  logic [7:0] lowIdx;
  logic       hasReq;

  // Lowest-numbered request wins
  always_comb begin
    lowIdx = '0;
    for (int n = NUM_PINS - 1; n >= 0; n--) begin
      if (reqVec[n]) lowIdx = 8'(n);
    end
  end

  assign hasReq = |reqVec;

  always_comb begin
    strobes.loadMsg = (stateQ == ST_IDLE) && hasReq;
    strobes.busy    = (stateQ == ST_SEND);
    strobes.msgDone = (stateQ == ST_SEND) && msgReady;
    strobes.pinIdx  = (stateQ == ST_SEND) ? curIdxQ : lowIdx;
  end

  assign msgValid = (stateQ == ST_SEND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      curIdxQ <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (hasReq) begin
          stateQ  <= ST_SEND;
          curIdxQ <= lowIdx;
        end
        ST_SEND: if (msgReady) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // No lower-numbered request is passed over (R12)
  p_lowest_first_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMsg |-> ((reqVec & ((NUM_PINS'(1) << strobes.pinIdx) - NUM_PINS'(1))) == '0));

  // The chosen line is actually requesting (R12)
  p_pick_valid_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMsg |-> |(reqVec & (NUM_PINS'(1) << strobes.pinIdx)));

  // Valid held until accepted (R9)
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> msgValid);

  // One message per handshake (R12)
  p_one_per_hs_r12: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> !msgValid);

endmodule

// File: rtl/irq_redir_msi.sv
module irq_redir_msi
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selWrEn,
  input  logic [7:0]          selWrData,
  input  logic                winWrEn,
  input  logic [31:0]         winWrData,
  output logic [31:0]         winRdData,
  input  logic [NUM_PINS-1:0] irqIn,
  input  logic                eoiValid,
  input  logic [7:0]          eoiVector,
  output logic                msgValid,
  input  logic                msgReady,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);

  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] reqVec;

  irq_router_dp #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .selWrEn   (selWrEn),
    .selWrData (selWrData),
    .winWrEn   (winWrEn),
    .winWrData (winWrData),
    .winRdData (winRdData),
    .irqIn     (irqIn),
    .eoiValid  (eoiValid),
    .eoiVector (eoiVector),
    .strobes   (strobes),
    .reqVec    (reqVec),
    .msgAddr   (msgAddr),
    .msgData   (msgData)
  );

  irq_router_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .msgReady (msgReady),
    .msgValid (msgValid),
    .strobes  (strobes)
  );

endmodule

// File: tb/tb_irq_redir_msi.sv
module tb_irq_redir_msi;

  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selWrEn = 1'b0;
  logic [7:0]    selWrData = '0;
  logic          winWrEn = 1'b0;
  logic [31:0]   winWrData = '0;
  logic [31:0]   winRdData;
  logic [NP-1:0] irqIn = '0;
  logic          eoiValid = 1'b0;
  logic [7:0]    eoiVector = '0;
  logic          msgValid;
  logic          msgReady = 1'b0;
  logic [31:0]   msgAddr;
  logic [31:0]   msgData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_redir_msi #(.NUM_PINS(NP)) dut (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrData(selWrData),
    .winWrEn(winWrEn), .winWrData(winWrData), .winRdData(winRdData),
    .irqIn(irqIn), .eoiValid(eoiValid), .eoiVector(eoiVector),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr), .msgData(msgData)
  );

  function automatic logic [7:0] lo(input int n); return 8'(16 + 2 * n); endfunction
  function automatic logic [7:0] hi(input int n); return 8'(17 + 2 * n); endfunction

  function automatic logic [31:0] loWord(input logic [7:0] vec, input logic [2:0] dm,
      input logic dl, input logic pol, input logic trig, input logic msk);
    return {15'h0, msk, trig, 1'b0, pol, 1'b0, dl, dm, vec};
  endfunction

  function automatic logic [31:0] expAddr(input logic [7:0] dest, input logic dl, input logic [2:0] dm);
    return {12'hFEE, dest, 8'h00, dm == 3'b001, dl, 2'b00};
  endfunction

  function automatic logic [31:0] expData(input logic [7:0] vec, input logic [2:0] dm, input logic trig);
    return {16'h0, trig, 1'b1, 3'b000, dm, vec};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wrReg(input logic [7:0] idx, input logic [31:0] data);
    selWrEn = 1'b1; selWrData = idx;
    @(negedge clk);
    selWrEn = 1'b0; winWrEn = 1'b1; winWrData = data;
    @(negedge clk);
    winWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [31:0] data);
    selWrEn = 1'b1; selWrData = idx;
    @(negedge clk);
    selWrEn = 1'b0;
    data = winRdData;
  endtask

  task automatic waitMsg(input int maxc, output bit got, output logic [31:0] a, output logic [31:0] d);
    got = 1'b0; a = '0; d = '0;
    for (int i = 0; i < maxc && !got; i++) begin
      if (msgValid) begin
        got = 1'b1; a = msgAddr; d = msgData;
        msgReady = 1'b1;
        @(negedge clk);
        msgReady = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic noMsg(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (msgValid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, 32'(seen), 32'h0);
  endtask

  task automatic sendEoi(input logic [7:0] v);
    eoiValid = 1'b1; eoiVector = v;
    @(negedge clk);
    eoiValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, a, d, a0;
    bit got;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(msgValid == 1'b0, "R1 msgValid", 32'(msgValid), 32'h0);
    rdReg(8'h00, r); chk(r == 32'h0, "R1 id", r, 32'h0);
    for (int p = 0; p < NP; p++) begin
      rdReg(lo(p), r); chk(r == 32'h0001_0000, "R1 entry low", r, 32'h0001_0000);
      rdReg(hi(p), r); chk(r == 32'h0, "R1 entry high", r, 32'h0);
    end

    // R2: index map and write masks
    wrReg(8'h00, 32'hFFFF_FFFF);
    rdReg(8'h00, r); chk(r == 32'h0F00_0000, "R2 id mask", r, 32'h0F00_0000);
    wrReg(8'h01, 32'hFFFF_FFFF);
    rdReg(8'h01, r); chk(r == {8'h0, 8'(NP - 1), 8'h0, 8'h20}, "R2 version", r, {8'h0, 8'(NP - 1), 8'h0, 8'h20});
    rdReg(8'h02, r); chk(r == 32'h0, "R2 unmapped low", r, 32'h0);
    rdReg(8'(16 + 2 * NP), r); chk(r == 32'h0, "R2 unmapped past table", r, 32'h0);

    // R3: writable bits of every entry, status bits read-only
    for (int p = 0; p < NP; p++) begin
      wrReg(lo(p), 32'hFFFF_FFFF);
      wrReg(hi(p), 32'hFFFF_FFFF);
      rdReg(lo(p), r); chk(r == 32'h0001_AFFF, "R3 low word mask", r, 32'h0001_AFFF);
      rdReg(hi(p), r); chk(r == 32'hFF00_0000, "R2 high word mask", r, 32'hFF00_0000);
      wrReg(lo(p), 32'h0001_0000);
      wrReg(hi(p), 32'h0);
    end

    // R4/R5/R6: edge sweep over lines and polarities
    for (int p = 0; p < NP; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [2:0] dm = 3'((p + pol * 3) % 8);
        logic       dl = 1'((p + pol) & 1);
        logic [7:0] vec = 8'(8'h30 + p * 2 + pol);
        logic [7:0] dest = 8'(8'h40 + p);
        irqIn[p] = 1'(pol);
        @(negedge clk);
        wrReg(hi(p), {dest, 24'h0});
        wrReg(lo(p), loWord(vec, dm, dl, 1'(pol), 1'b0, 1'b0));
        noMsg(3, "R6 idle line");
        irqIn[p] = ~1'(pol);
        waitMsg(12, got, a, d);
        chk(got, "R6 edge message", 32'(got), 32'h1);
        chk(a == expAddr(dest, dl, dm), "R4 address", a, expAddr(dest, dl, dm));
        chk(d == expData(vec, dm, 1'b0), "R5 data", d, expData(vec, dm, 1'b0));
        noMsg(6, "R6 held active");
        irqIn[p] = 1'(pol);
        noMsg(6, "R6 return inactive");
        wrReg(lo(p), 32'h0001_0000);
        irqIn[p] = 1'b0;
        @(negedge clk);
      end
    end

    // R7: masked edge line
    wrReg(lo(2), loWord(8'h52, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1));
    irqIn[2] = 1'b1;
    noMsg(8, "R7 masked edge");
    rdReg(lo(2), r); chk(r[12] == 1'b0, "R7 masked status", 32'(r[12]), 32'h0);
    wrReg(lo(2), loWord(8'h52, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0));
    noMsg(8, "R7 edge lost while masked");
    irqIn[2] = 1'b0;
    wrReg(lo(2), 32'h0001_0000);

    // R8/R9: stalled port
    wrReg(hi(3), 32'h7700_0000);
    wrReg(lo(3), loWord(8'h55, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0));
    irqIn[3] = 1'b1;
    @(negedge clk);
    rdReg(lo(3), r); chk(r[12] == 1'b1, "R8 status before send", 32'(r[12]), 32'h1);
    @(negedge clk);
    a0 = msgAddr;
    for (int i = 0; i < 5; i++) begin
      chk(msgValid == 1'b1, "R9 valid held", 32'(msgValid), 32'h1);
      chk(msgAddr == a0, "R9 address stable", msgAddr, a0);
      @(negedge clk);
    end
    rdReg(lo(3), r); chk(r[12] == 1'b1, "R8 status while stalled", 32'(r[12]), 32'h1);
    waitMsg(4, got, a, d);
    chk(got && a == expAddr(8'h77, 1'b1, 3'b100), "R9 stalled message address", a, expAddr(8'h77, 1'b1, 3'b100));
    chk(d == expData(8'h55, 3'b100, 1'b0), "R9 stalled message data", d, expData(8'h55, 3'b100, 1'b0));
    rdReg(lo(3), r); chk(r[12] == 1'b0, "R8 status after handshake", 32'(r[12]), 32'h0);
    irqIn[3] = 1'b0;
    wrReg(lo(3), 32'h0001_0000);

    // R10/R11: level line with remote IRR
    wrReg(hi(4), 32'h0900_0000);
    wrReg(lo(4), loWord(8'h66, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0));
    irqIn[4] = 1'b1;
    waitMsg(12, got, a, d);
    chk(got && d == expData(8'h66, 3'b000, 1'b1), "R10 level message", d, expData(8'h66, 3'b000, 1'b1));
    rdReg(lo(4), r); chk(r[14] == 1'b1, "R10 remote IRR set", 32'(r[14]), 32'h1);
    noMsg(10, "R10 blocked while IRR");
    sendEoi(8'h67);
    noMsg(10, "R10 wrong EOI vector");
    rdReg(lo(4), r); chk(r[14] == 1'b1, "R10 IRR kept on mismatch", 32'(r[14]), 32'h1);
    sendEoi(8'h66);
    waitMsg(12, got, a, d);
    chk(got, "R11 resend after EOI", 32'(got), 32'h1);
    irqIn[4] = 1'b0;
    sendEoi(8'h66);
    rdReg(lo(4), r); chk(r[14] == 1'b0, "R11 IRR cleared", 32'(r[14]), 32'h0);
    noMsg(8, "R11 inactive after EOI");
    wrReg(lo(4), 32'h0001_0000);

    // R7: level line unmasked while active
    wrReg(lo(5), loWord(8'h77, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1));
    irqIn[5] = 1'b0;
    noMsg(8, "R7 masked level");
    wrReg(lo(5), loWord(8'h77, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0));
    waitMsg(12, got, a, d);
    chk(got && d[7:0] == 8'h77, "R7 level after unmask", d, expData(8'h77, 3'b000, 1'b1));
    wrReg(lo(5), 32'h0001_0000);
    irqIn[5] = 1'b1;
    sendEoi(8'h77);

    // R12: all lines at once, ascending order
    irqIn = '0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) wrReg(lo(p), loWord(8'(8'h80 + p), 3'b000, 1'b0, 1'b0, 1'b0, 1'b0));
    irqIn = '1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < NP; k++) begin
      waitMsg(12, got, a, d);
      chk(got && d[7:0] == 8'(8'h80 + k), "R12 ascending order", d, 32'(8'h80 + k));
    end
    noMsg(10, "R12 one message per line");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule